// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the servicing core of an eight-line interrupt controller. Each request line is captured into a request register, either on a rising edge or by following the line's level. The capture mode is a static configuration input. Requests whose mask bit is set are still recorded but never compete. The remaining requests are arbitrated on a priority ring. The ring is defined by which level currently ranks lowest, and the comparison is against the levels already in service. While a request is allowed through, the block raises its interrupt line to the processor.

When the processor strobes acknowledge, the winning level moves from the request register to the in-service register. One cycle later the block presents the vector: the upper bits of a programmable base with the level number in the low bits. Command pulses from a separate decoder do the following:
- retire in-service levels, either the top one, a named one, or the top one with rotation;
- reprogram the lowest-priority level;
- turn a special mask mode on or off, in which levels in service stop blocking other requests.

Both the request register and the in-service register are brought out for read-back.

Top module: `prio_irq_core`

## Requirements
- R1: In edge mode (`level_mode`=0), a request bit is set only by a 0-to-1 change of its input. A line held high after its request was acknowledged does not set the bit again.
- R2: In level mode (`level_mode`=1), each request bit equals its input as sampled on the previous clock edge.
- R3: A level whose `mask` bit is 1 still has its request bit captured and readable on `irr_q`. It never causes `irq` and is never granted.
- R4: With lowest level L, level (L+1+k) mod 8 has rank k, where rank 0 is the highest priority. The pending unmasked request of lowest rank is the winner.
- R5: Outside special mask mode, `irq` is 1 only when the winner ranks strictly higher than every in-service level.
- R6: `inta` while `irq`=1 has three effects: it sets the winner's bit in `isr_q`, clears that bit in `irr_q`, and on the next cycle raises `vec_valid` for one cycle with `vec_out` = {`vec_base`[7:3], level}. `inta` while `irq`=0 changes nothing and gives no `vec_valid`.
- R7: `eoi_nonspec` clears the lowest-ranked (highest-priority) set bit of `isr_q`.
- R8: `eoi_spec` clears only bit `eoi_level` of `isr_q`.
- R9: `eoi_rot` clears the highest-priority in-service bit and makes that level the new lowest level.
- R10: `prio_set` makes `prio_lowest` the lowest level. It takes precedence over a rotation in the same cycle.
- R11: In special mask mode (`smm_on` sets it, `smm_off` clears it, and clear wins), in-service levels do not block other requests. A level that is itself in service is not granted again.
- R12: After reset, `irr_q`=0, `isr_q`=0, `irq`=0, special mask mode is off and the lowest level is 7, so level 0 ranks highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_mode | input | 1 | 1 = level-sensitive capture, 0 = edge-sensitive capture |
| req_in | input | 8 | Request lines |
| mask | input | 8 | 1 = level may not interrupt |
| vec_base | input | 8 | Vector base; bits 7:3 are used |
| inta | input | 1 | Acknowledge strobe |
| eoi_nonspec | input | 1 | Retire the highest-priority in-service level |
| eoi_spec | input | 1 | Retire level `eoi_level` |
| eoi_rot | input | 1 | Retire the top in-service level and make it lowest |
| eoi_level | input | 3 | Level named by `eoi_spec` |
| prio_set | input | 1 | Load the lowest level from `prio_lowest` |
| prio_lowest | input | 3 | New lowest level |
| smm_on | input | 1 | Enter special mask mode |
| smm_off | input | 1 | Leave special mask mode |
| irq | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector strobe, one cycle after a granted acknowledge |
| vec_out | output | 8 | Vector |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |

## Verification
A wrong lowest-level register is invisible until two or more requests compete. It then shows in the first vector that follows, so every priority rotation is swept against every request pattern and each pattern is drained to the end. A stale or misplaced in-service bit shows on `isr_q` in the cycle after the acknowledge or retire command that caused it. It also shows at once on `irq`, which either stays low when it should rise or rises when it should stay blocked. A capture fault in the request register shows on `irr_q` one clock after the line changes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // which in-service bit a retire command selects
   typedef enum logic [1:0] {
      RET_NONE  = 2'd0,
      RET_TOP   = 2'd1,
      RET_NAMED = 2'd2
   } retire_sel_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               level_mode,
   input  logic [N_LINES-1:0] req_in,
   input  logic [N_LINES-1:0] ack_clr,
   output logic [N_LINES-1:0] irr
);
   logic [N_LINES-1:0] prev_q;

   for (genvar i = 0; i < int'(N_LINES); i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            irr[i]    <= 1'b0;
         end else begin
            prev_q[i] <= req_in[i];
            if (level_mode)
               irr[i] <= req_in[i] & ~ack_clr[i];
            else
               irr[i] <= (req_in[i] & ~prev_q[i]) | (irr[i] & ~ack_clr[i]);
         end
      end

      // a low line cannot create a request in edge mode
      AST_EDGE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_mode && !req_in[i] && !irr[i]) |=> !irr[i]) else $error("edge capture without a rise"); // R1
      // a cleared request stays cleared while the line is held high in edge mode
      AST_EDGE_NO_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (!level_mode && req_in[i] && prev_q[i] && !irr[i]) |=> !irr[i]) else $error("held line re-latched"); // R1
   end
endmodule

// File: rtl/irq_ring_pick.sv
module irq_ring_pick #(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned LVL_W   = 3
) (
   input  logic [N_LINES-1:0] bits,
   input  logic [LVL_W-1:0]   lowest,
   output logic               found,
   output logic [LVL_W-1:0]   level
);
   logic [LVL_W-1:0] pos;

   // walk from lowest rank upward so the highest rank overwrites last
   always_comb begin
      found = 1'b0;
      level = lowest;
      pos   = '0;
      for (int k = int'(N_LINES) - 1; k >= 0; k--) begin
         pos = lowest + LVL_W'(1) + LVL_W'(k);
         if (bits[pos]) begin
            found = 1'b1;
            level = pos;
         end
      end
   end

   always_comb begin
      AST_PICK_HIT: assert (!found || bits[level]) else $error("picked an empty level"); // R4
   end
endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core
   import prio_irq_pkg::*;
#(
   parameter int unsigned N_LINES    = 8,
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned RST_LOWEST = N_LINES - 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       level_mode,
   input  logic [N_LINES-1:0]         req_in,
   input  logic [N_LINES-1:0]         mask,
   input  logic [VEC_W-1:0]           vec_base,
   input  logic                       inta,
   input  logic                       eoi_nonspec,
   input  logic                       eoi_spec,
   input  logic                       eoi_rot,
   input  logic [$clog2(N_LINES)-1:0] eoi_level,
   input  logic                       prio_set,
   input  logic [$clog2(N_LINES)-1:0] prio_lowest,
   input  logic                       smm_on,
   input  logic                       smm_off,
   output logic                       irq,
   output logic                       vec_valid,
   output logic [VEC_W-1:0]           vec_out,
   output logic [N_LINES-1:0]         irr_q,
   output logic [N_LINES-1:0]         isr_q
);
   localparam int unsigned LVL_W = $clog2(N_LINES);

   if (N_LINES < 2 || N_LINES != (1 << LVL_W)) begin : g_bad_lines
      $error("N_LINES must be a power of two, at least 2");
   end
   if (VEC_W <= LVL_W) begin : g_bad_vec
      $error("VEC_W must exceed the level width");
   end
   if (RST_LOWEST >= N_LINES) begin : g_bad_rst
      $error("RST_LOWEST out of range");
   end

   logic [LVL_W-1:0]   lowest_q;
   logic               smm_q;
   logic [N_LINES-1:0] pend, cand, ack_vec, isr_clr;
   logic               win_found, top_found, grant, ack;
   logic [LVL_W-1:0]   win_lvl, top_lvl, win_rank, top_rank;
   retire_sel_e        ret_sel;

   irq_req_latch #(.N_LINES(N_LINES)) i_latch (
      .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
      .req_in(req_in), .ack_clr(ack_vec), .irr(irr_q)
   );

   assign pend = irr_q & ~mask;
   assign cand = smm_q ? (pend & ~isr_q) : pend;

   irq_ring_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) i_pick_req (
      .bits(cand), .lowest(lowest_q), .found(win_found), .level(win_lvl)
   );
   irq_ring_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) i_pick_isr (
      .bits(isr_q), .lowest(lowest_q), .found(top_found), .level(top_lvl)
   );

   // rank 0 is the level just above the lowest one
   assign win_rank = win_lvl - lowest_q - LVL_W'(1);
   assign top_rank = top_lvl - lowest_q - LVL_W'(1);

   assign grant   = win_found && (smm_q || !top_found || (win_rank < top_rank));
   assign irq     = grant;
   assign ack     = inta && grant;
   assign ack_vec = ack ? (N_LINES'(1) << win_lvl) : '0;

   always_comb begin
      if (eoi_spec)
         ret_sel = RET_NAMED;
      else if ((eoi_nonspec || eoi_rot) && top_found)
         ret_sel = RET_TOP;
      else
         ret_sel = RET_NONE;
      case (ret_sel)
         RET_NAMED: isr_clr = N_LINES'(1) << eoi_level;
         RET_TOP:   isr_clr = N_LINES'(1) << top_lvl;
         default:   isr_clr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q     <= '0;
         lowest_q  <= LVL_W'(RST_LOWEST);
         smm_q     <= 1'b0;
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         isr_q <= (isr_q & ~isr_clr) | ack_vec;
         if (prio_set)
            lowest_q <= prio_lowest;
         else if (eoi_rot && !eoi_spec && top_found)
            lowest_q <= top_lvl;
         if (smm_off)
            smm_q <= 1'b0;
         else if (smm_on)
            smm_q <= 1'b1;
         vec_valid <= ack;
         if (ack)
            vec_out <= {vec_base[VEC_W-1:LVL_W], win_lvl};
      end
   end

   AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |(irr_q & ~mask)) else $error("irq without unmasked request"); // R3
   AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && irq && !eoi_nonspec && !eoi_spec && !eoi_rot) |=>
         ($countones(isr_q) == $countones($past(isr_q)) + 1)) else $error("ack did not add one level"); // R6
   AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(inta && irq)) else $error("vector without grant"); // R6
   AST_SPEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_spec && !inta) |=> !isr_q[$past(eoi_level)]) else $error("named level still in service"); // R8
   AST_ROT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_rot && !eoi_spec && !prio_set && |isr_q) |=> (lowest_q == $past(top_lvl))) else $error("rotation missed"); // R9
   AST_NORMAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!smm_q && isr_q[lowest_q + LVL_W'(1)]) |-> !irq) else $error("top-rank service did not block"); // R5
endmodule

// File: tb/test_prio_irq_core.sv
module test_prio_irq_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       level_mode = 1'b0;
   logic [7:0] req_in = '0, mask = '0, vec_base = 8'hA8;
   logic       inta = 1'b0, eoi_nonspec = 1'b0, eoi_spec = 1'b0, eoi_rot = 1'b0;
   logic [2:0] eoi_level = '0, prio_lowest = '0;
   logic       prio_set = 1'b0, smm_on = 1'b0, smm_off = 1'b0;
   logic       irq, vec_valid;
   logic [7:0] vec_out, irr_q, isr_q;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prio_irq_core i_prio_irq_core (
      .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .req_in(req_in), .mask(mask),
      .vec_base(vec_base), .inta(inta), .eoi_nonspec(eoi_nonspec), .eoi_spec(eoi_spec),
      .eoi_rot(eoi_rot), .eoi_level(eoi_level), .prio_set(prio_set), .prio_lowest(prio_lowest),
      .smm_on(smm_on), .smm_off(smm_off), .irq(irq), .vec_valid(vec_valid), .vec_out(vec_out),
      .irr_q(irr_q), .isr_q(isr_q)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // expected winner from ring arithmetic
   function automatic int ring_top(input int bits, input int low);
      for (int k = 0; k < 8; k++) begin
         int lv = (low + 1 + k) % 8;
         if (bits[lv]) return lv;
      end
      return -1;
   endfunction

   task automatic pulse_req(input logic [7:0] p);
      req_in = p; cyc(); req_in = '0; cyc();
   endtask
   task automatic do_ack();
      inta = 1'b1; cyc(); inta = 1'b0;
   endtask
   task automatic ack_expect(input string req, input int lvl);
      do_ack();
      chk(req, "vec_valid", int'(vec_valid), 1);
      chk(req, "vec_out", int'(vec_out), int'(8'hA8) | lvl);
   endtask
   task automatic eoi_top();
      eoi_nonspec = 1'b1; cyc(); eoi_nonspec = 1'b0;
   endtask
   task automatic eoi_named(input int lvl);
      eoi_spec = 1'b1; eoi_level = 3'(lvl); cyc(); eoi_spec = 1'b0;
   endtask
   task automatic set_low(input int lvl);
      prio_set = 1'b1; prio_lowest = 3'(lvl); cyc(); prio_set = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R12 reset state
      chk("R12", "irr", int'(irr_q), 0);
      chk("R12", "isr", int'(isr_q), 0);
      chk("R12", "irq", int'(irq), 0);
      chk("R12", "vec_valid", int'(vec_valid), 0);
      pulse_req(8'h81);
      ack_expect("R12", 0);
      eoi_top();
      ack_expect("R12", 7);
      eoi_top();
      chk("R7", "isr empty", int'(isr_q), 0);

      // R5 nesting, R8 named retire, R7 top retire
      pulse_req(8'h20);
      ack_expect("R6", 5);
      chk("R6", "isr one", int'(isr_q), 8'h20);
      pulse_req(8'h04);
      chk("R5", "higher preempts", int'(irq), 1);
      ack_expect("R5", 2);
      chk("R6", "isr nested", int'(isr_q), 8'h24);
      eoi_named(5);
      chk("R8", "named only", int'(isr_q), 8'h04);
      pulse_req(8'h08);
      chk("R5", "lower blocked", int'(irq), 0);
      eoi_top();
      chk("R7", "isr after top", int'(isr_q), 0);
      chk("R5", "unblocked", int'(irq), 1);
      ack_expect("R5", 3);
      pulse_req(8'h01);
      ack_expect("R5", 0);
      chk("R6", "isr two", int'(isr_q), 8'h09);
      eoi_top();
      chk("R7", "top cleared first", int'(isr_q), 8'h08);
      eoi_top();

      // R9 rotating retire
      pulse_req(8'h08);
      ack_expect("R9", 3);
      eoi_rot = 1'b1; cyc(); eoi_rot = 1'b0;
      chk("R9", "isr cleared", int'(isr_q), 0);
      pulse_req(8'h18);
      ack_expect("R9", 4);
      eoi_top();
      ack_expect("R9", 3);
      eoi_top();

      // R10 explicit lowest, precedence over rotation
      pulse_req(8'h02);
      ack_expect("R10", 1);
      prio_set = 1'b1; prio_lowest = 3'd2; eoi_rot = 1'b1; cyc();
      prio_set = 1'b0; eoi_rot = 1'b0;
      pulse_req(8'h0C);
      ack_expect("R10", 3);
      eoi_top();
      ack_expect("R10", 2);
      eoi_top();
      set_low(7);

      // R11 special mask mode
      pulse_req(8'h01);
      ack_expect("R11", 0);
      pulse_req(8'h20);
      chk("R5", "blocked by top", int'(irq), 0);
      smm_on = 1'b1; cyc(); smm_on = 1'b0;
      chk("R11", "smm irq", int'(irq), 1);
      ack_expect("R11", 5);
      chk("R11", "isr", int'(isr_q), 8'h21);
      pulse_req(8'h01);
      chk("R11", "own level held", int'(irq), 0);
      chk("R11", "irr", int'(irr_q), 8'h01);
      eoi_named(5);
      eoi_named(0);
      chk("R11", "own level free", int'(irq), 1);
      smm_on = 1'b1; smm_off = 1'b1; cyc(); smm_on = 1'b0; smm_off = 1'b0;
      ack_expect("R11", 0);
      pulse_req(8'h10);
      chk("R11", "smm off blocks", int'(irq), 0);
      eoi_top();
      ack_expect("R11", 4);
      eoi_top();

      // R3 mask and R6 ungranted ack
      mask = 8'h10;
      pulse_req(8'h10);
      chk("R3", "irr masked", int'(irr_q), 8'h10);
      chk("R3", "irq masked", int'(irq), 0);
      do_ack();
      chk("R6", "no vec", int'(vec_valid), 0);
      chk("R6", "isr kept", int'(isr_q), 0);
      chk("R3", "irr kept", int'(irr_q), 8'h10);
      mask = 8'h00;
      cyc();
      chk("R3", "unmasked", int'(irq), 1);
      ack_expect("R3", 4);
      eoi_top();

      // R2 level capture
      level_mode = 1'b1;
      req_in = 8'h40; cyc();
      chk("R2", "follows high", int'(irr_q), 8'h40);
      req_in = 8'h00; cyc();
      chk("R2", "follows low", int'(irr_q), 0);
      chk("R2", "irq low", int'(irq), 0);
      level_mode = 1'b0;
      cyc();
      // R1 held line in edge mode
      req_in = 8'h40; cyc();
      chk("R1", "rise latched", int'(irr_q), 8'h40);
      ack_expect("R1", 6);
      eoi_top();
      cyc();
      chk("R1", "held no relatch", int'(irr_q), 0);
      chk("R1", "held no irq", int'(irq), 0);
      req_in = 8'h00; cyc();

      // R4 sweep: every lowest level against every request pattern
      for (int low = 0; low < 8; low++) begin
         set_low(low);
         for (int p = 1; p < 256; p++) begin
            int rem;
            req_in = 8'(p); cyc();
            chk("R1", "sweep capture", int'(irr_q), p);
            req_in = '0;
            rem = p;
            while (rem != 0) begin
               int w;
               w = ring_top(rem, low);
               chk("R4", "irq pending", int'(irq), 1);
               ack_expect("R4", w);
               rem = rem & ~(1 << w);
               chk("R6", "irr after ack", int'(irr_q), rem);
               chk("R6", "isr after ack", int'(isr_q), 1 << w);
               if (rem != 0) chk("R5", "lower blocked", int'(irq), 0);
               eoi_top();
               chk("R7", "isr retired", int'(isr_q), 0);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule